// File: doc/BRIEF.md
# Single-wire Manchester bus slave front end

This block is the bit-level front end of a slave on a single open-drain line that carries clock and data together in Manchester form. It runs on a system clock many times faster than the bus bit rate. It does not rely on a fixed bus speed. It finds the bit period by timing the synchronising header that opens every command. It then decodes each incoming bit from the direction of its mid-bit transition. When asked, it sends bytes and acknowledge bits by pulling the line low through an output enable.

A command sequencer sits above the block. The sequencer sees received bytes as single-cycle pulses and sees each master acknowledge as its own pulse. It queues a byte to send with a one-cycle start strobe. It chooses for every slave acknowledge slot whether to answer with a low-then-high edge or with silence. The timing reference is re-centred on the mid-bit edge of every master acknowledge bit, and on no other bit. This lets a command survive slow drift of the master clock. If an expected edge does not come, the block drops into an idle state and stays there until the line has been held high long enough to count as a standby pulse.

Top module: `mbus_slave_phy`

## Requirements
- R1: Out of reset, line_oe, busy, rx_valid, mak_valid and miss_edge are all 0.
- R2: A standby pulse is recognised only after at least one low-to-high transition of the line since reset. The line must then stay high for STBY_CYC clocks. Recognition gives a one-cycle stby_seen pulse, after which busy is 0 and the block waits for a header.
- R3: A header is a low pulse of at least HDR_LOW_MIN clocks followed by the byte 01010101. A shorter low pulse does not start a command, and busy stays 0.
- R4: The bit period is one quarter of the time between the first and fifth mid-bit edges of the header. In a receive byte, a falling mid-bit edge is a 0 and a rising one is a 1, sent MSB first. The finished byte is presented on rx_byte with a one-cycle rx_valid pulse.
- R5: The slave acknowledge slot that follows the header is always silent (no drive), whatever slave_ack_en is.
- R6: After each byte, the master acknowledge bit is decoded (rising = 1 = continue) onto master_ack with a one-cycle mak_valid pulse. In the slave slot that follows, slave_ack_en = 1 drives the line low for the first half and releases it for the second half. slave_ack_en = 0 drives nothing.
- R7: A tx_start strobe, given no later than the middle of a slave acknowledge slot, latches tx_byte. The next byte slot then sends that byte MSB first: line_oe equals the bit value in the first half and its inverse in the second half. No rx_valid is produced for that slot.
- R8: The mid-bit edge of each master acknowledge bit becomes the new timing reference. Phase steps of up to a quarter period at successive acknowledge bits therefore do not add up into a missed edge.
- R9: A receive mid-bit edge that does not arrive within a quarter period of its expected position causes a one-cycle miss_edge pulse and busy = 0. Later line activity produces no rx_valid or mak_valid until a standby pulse.
- R10: A master acknowledge of 0 ends the command after the slave slot. busy falls, and a new header is accepted without a standby pulse.
- R11: line_oe is asserted only while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared bus line |
| line_oe | output | 1 | Pull the line low when 1 |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| master_ack | output | 1 | Last decoded master acknowledge bit |
| mak_valid | output | 1 | One-cycle strobe for master_ack |
| tx_byte | input | 8 | Byte to send in the next byte slot |
| tx_start | input | 1 | Latch tx_byte for sending |
| slave_ack_en | input | 1 | Answer the next slave slot with an acknowledge |
| miss_edge | output | 1 | One-cycle strobe: expected edge missing |
| stby_seen | output | 1 | One-cycle strobe: standby pulse recognised |
| busy | output | 1 | A command is in progress |

## Verification
Receive bytes are chosen so that the decoder must tell rising from falling mid-bit edges. These include alternating patterns, all-ones, single-bit patterns, and bytes with long runs that create bit-boundary edges the window must ignore. The transmit test sends a mixed byte and checks that each bit's second half is the inverse of its first half. Acknowledge slots are tried with the enable both high and low, and also directly after the header, where silence is compulsory. Two successive quarter-period-scale phase steps at acknowledge bits separate an engine that re-centres from one that does not. Silence on the line and a header pulse that is too short exercise the miss, idle and ignore paths.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SLEEP,
        S_HLOW,
        S_HSYNC,
        S_DATA,
        S_MAK,
        S_SAK
    } slot_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

    // Edge accepted when within a quarter period of the expected position.
    function automatic logic in_win(input int p, input int t);
        return (p >= t - (t >>> 2)) && (p <= t + (t >>> 2));
    endfunction

    function automatic logic past_win(input int p, input int t);
        return p > t + (t >>> 2);
    endfunction

endpackage

// File: rtl/mbus_edge_sync.sv
module mbus_edge_sync
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    output line_ev_t ev
);
    logic [1:0] sy;
    logic       prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= 2'b11;
            prev <= 1'b1;
        end else begin
            sy   <= {sy[0], line_in};
            prev <= sy[1];
        end
    end

    assign ev.lvl  = sy[1];
    assign ev.rise = sy[1] & ~prev;
    assign ev.fall = ~sy[1] & prev;
endmodule

// File: rtl/mbus_standby_det.sv
module mbus_standby_det
    import mbus_pkg::*;
#(
    parameter int STBY_CYC = 60000
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output logic     stby
);
    localparam int HW = $clog2(STBY_CYC + 1);

    logic [HW-1:0] hcnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt  <= '0;
            armed <= 1'b0;
            stby  <= 1'b0;
        end else begin
            stby <= 1'b0;
            if (ev.rise) armed <= 1'b1;
            if (!ev.lvl)
                hcnt <= '0;
            else if (hcnt != HW'(STBY_CYC))
                hcnt <= hcnt + 1'b1;
            if (ev.lvl && armed && hcnt == HW'(STBY_CYC - 1))
                stby <= 1'b1;
        end
    end
endmodule

// File: rtl/mbus_slot_engine.sv
module mbus_slot_engine
    import mbus_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int HDR_LOW_MIN = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic       stby,
    input  logic [7:0] tx_byte,
    input  logic       tx_start,
    input  logic       slave_ack_en,
    output logic       line_oe,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       master_ack,
    output logic       mak_valid,
    output logic       miss_edge,
    output logic       busy
);
    localparam int PW     = CNT_W + 2;
    localparam int PH_MAX = 1 << CNT_W;
    localparam logic signed [PW-1:0] ONE = PW'(1);

    slot_e                 st;
    logic signed [PW-1:0]  ph;
    logic [CNT_W-1:0]      per;
    logic [2:0]            idx;
    logic [7:0]            sh, tx_buf;
    logic                  tx_mode, tx_pend, hdr_ack;

    int   phi, peri;
    logic edge_any, win, late, at_half, at_end, sak_v;

    always_comb begin
        phi      = int'(ph);
        peri     = int'(per);
        edge_any = ev.rise | ev.fall;
        win      = in_win(phi, peri);
        late     = past_win(phi, peri);
        at_half  = (phi == (peri >>> 1));
        at_end   = (phi == peri);
        sak_v    = !hdr_ack && slave_ack_en;
        busy     = st inside {S_HSYNC, S_DATA, S_MAK, S_SAK};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            ph         <= '0;
            per        <= '0;
            idx        <= '0;
            sh         <= '0;
            tx_buf     <= '0;
            tx_mode    <= 1'b0;
            tx_pend    <= 1'b0;
            hdr_ack    <= 1'b0;
            line_oe    <= 1'b0;
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            master_ack <= 1'b0;
            mak_valid  <= 1'b0;
            miss_edge  <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            mak_valid <= 1'b0;
            miss_edge <= 1'b0;
            if (tx_start) begin
                tx_pend <= 1'b1;
                tx_buf  <= tx_byte;
            end
            if (stby) begin
                st      <= S_SLEEP;
                ph      <= '0;
                line_oe <= 1'b0;
            end else begin
                case (st)
                    S_IDLE: ;
                    S_SLEEP: if (ev.fall) begin
                        st <= S_HLOW;
                        ph <= ONE;
                    end
                    S_HLOW: begin
                        if (ev.rise) begin
                            if (phi >= HDR_LOW_MIN) begin
                                st  <= S_HSYNC;
                                idx <= '0;
                                ph  <= '0;
                            end else begin
                                st <= S_SLEEP;
                            end
                        end else if (phi < HDR_LOW_MIN) begin
                            ph <= ph + ONE;
                        end
                    end
                    S_HSYNC: begin
                        ph <= ph + ONE;
                        if (edge_any) begin
                            idx <= idx + 3'd1;
                            if (idx == 3'd0) ph <= ONE;
                            if (idx == 3'd4) per <= ph[CNT_W+1:2];
                            if (idx == 3'd7) begin
                                st      <= S_MAK;
                                ph      <= ONE;
                                hdr_ack <= 1'b1;
                            end
                        end else if (phi >= PH_MAX) begin
                            st <= S_IDLE;
                        end
                    end
                    S_DATA: begin
                        ph <= ph + ONE;
                        if (tx_mode) begin
                            if (at_half) line_oe <= sh[7];
                            if (at_end) begin
                                line_oe <= ~sh[7];
                                sh      <= {sh[6:0], 1'b0};
                                ph      <= ONE;
                                idx     <= idx + 3'd1;
                                if (idx == 3'd7) st <= S_MAK;
                            end
                        end else begin
                            if (at_half) line_oe <= 1'b0;
                            if (edge_any && win) begin
                                sh  <= {sh[6:0], ev.rise};
                                ph  <= ph + ONE - $signed({2'b00, per});
                                idx <= idx + 3'd1;
                                if (idx == 3'd7) begin
                                    rx_byte  <= {sh[6:0], ev.rise};
                                    rx_valid <= 1'b1;
                                    st       <= S_MAK;
                                end
                            end else if (late) begin
                                st        <= S_IDLE;
                                miss_edge <= 1'b1;
                                line_oe   <= 1'b0;
                            end
                        end
                    end
                    S_MAK: begin
                        ph <= ph + ONE;
                        if (at_half) line_oe <= 1'b0;
                        if (edge_any && win) begin
                            master_ack <= ev.rise;
                            mak_valid  <= !hdr_ack;
                            ph         <= ONE;
                            st         <= S_SAK;
                        end else if (late) begin
                            st        <= S_IDLE;
                            miss_edge <= 1'b1;
                            line_oe   <= 1'b0;
                        end
                    end
                    S_SAK: begin
                        ph <= ph + ONE;
                        if (at_half) line_oe <= sak_v;
                        if (at_end) begin
                            line_oe <= 1'b0;
                            ph      <= ONE;
                            hdr_ack <= 1'b0;
                            idx     <= '0;
                            if (!master_ack) begin
                                st <= S_SLEEP;
                            end else begin
                                st      <= S_DATA;
                                tx_mode <= tx_pend;
                                sh      <= tx_buf;
                                tx_pend <= 1'b0;
                            end
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbus_slave_phy.sv
module mbus_slave_phy
    import mbus_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int HDR_LOW_MIN = 500,
    parameter int STBY_CYC    = 60000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output logic       line_oe,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       master_ack,
    output logic       mak_valid,
    input  logic [7:0] tx_byte,
    input  logic       tx_start,
    input  logic       slave_ack_en,
    output logic       miss_edge,
    output logic       stby_seen,
    output logic       busy
);
    line_ev_t ev;

    mbus_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .ev      (ev)
    );

    mbus_standby_det #(.STBY_CYC(STBY_CYC)) u_stby (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .stby (stby_seen)
    );

    mbus_slot_engine #(.CNT_W(CNT_W), .HDR_LOW_MIN(HDR_LOW_MIN)) u_eng (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .stby         (stby_seen),
        .tx_byte      (tx_byte),
        .tx_start     (tx_start),
        .slave_ack_en (slave_ack_en),
        .line_oe      (line_oe),
        .rx_byte      (rx_byte),
        .rx_valid     (rx_valid),
        .master_ack   (master_ack),
        .mak_valid    (mak_valid),
        .miss_edge    (miss_edge),
        .busy         (busy)
    );
endmodule

// File: rtl/mbus_slave_phy_chk.sv
module mbus_slave_phy_chk (
    input logic clk,
    input logic rst,
    input logic line_oe,
    input logic busy,
    input logic rx_valid,
    input logic mak_valid,
    input logic miss_edge,
    input logic stby_seen
);
    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) line_oe |-> busy); // R11
    AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R4
    AST_MISS_ENDS_CMD: assert property (@(posedge clk) disable iff (rst) miss_edge |-> !busy); // R9
    AST_STBY_QUIETS: assert property (@(posedge clk) disable iff (rst) stby_seen |=> (!busy && !line_oe)); // R2
    AST_MAKV_EXCL_RXV: assert property (@(posedge clk) disable iff (rst) mak_valid |-> !rx_valid); // R6
endmodule

bind mbus_slave_phy mbus_slave_phy_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_oe   (line_oe),
    .busy      (busy),
    .rx_valid  (rx_valid),
    .mak_valid (mak_valid),
    .miss_edge (miss_edge),
    .stby_seen (stby_seen)
);

// File: tb/mbus_slave_phy_test.sv
module mbus_slave_phy_test;
    localparam int BT    = 40;
    localparam int STBY  = 400;
    localparam int HLMIN = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_low = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_start = 1'b0;
    logic       sae = 1'b0;
    logic       line_in, line_oe, rx_valid, master_ack, mak_valid;
    logic       miss_edge, stby_seen, busy;
    logic [7:0] rx_byte;

    int errors = 0, checks = 0, miss_cnt = 0, stby_cnt = 0, rx_cnt = 0;
    bit done = 0;
    logic [7:0] exp_rx[$];
    logic       exp_mak[$];

    always #5 clk = ~clk;
    assign line_in = ~(m_low | line_oe);

    mbus_slave_phy #(.CNT_W(12), .HDR_LOW_MIN(HLMIN), .STBY_CYC(STBY)) uut (
        .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .master_ack(master_ack),
        .mak_valid(mak_valid), .tx_byte(tx_byte), .tx_start(tx_start),
        .slave_ack_en(sae), .miss_edge(miss_edge), .stby_seen(stby_seen),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: queues of expected strobes, compared every clock
    always @(negedge clk) begin
        if (!rst && done == 0) begin
            if (miss_edge) miss_cnt++;
            if (stby_seen) stby_cnt++;
            if (rx_valid) begin
                rx_cnt++;
                if (exp_rx.size() == 0) chk(0, "R4 R7 R9 unexpected rx_valid", rx_byte, 0);
                else begin
                    automatic logic [7:0] e = exp_rx.pop_front();
                    chk(rx_byte == e, "R4 rx_byte", rx_byte, e);
                end
            end
            if (mak_valid) begin
                if (exp_mak.size() == 0) chk(0, "R6 R9 unexpected mak_valid", master_ack, 0);
                else begin
                    automatic logic e = exp_mak.pop_front();
                    chk(master_ack == e, "R6 master_ack", master_ack, e);
                end
            end
        end
    end

    task automatic mbit(input logic v, input int extra);
        m_low = v;
        tick(BT / 2 + extra);
        m_low = ~v;
        tick(BT / 2);
    endtask

    task automatic mbyte(input logic [7:0] b, input bit expect_rx);
        if (expect_rx) exp_rx.push_back(b);
        for (int i = 7; i >= 0; i--) mbit(b[i], 0);
    endtask

    task automatic mak(input logic v, input int extra, input bit expect_mak);
        if (expect_mak) exp_mak.push_back(v);
        mbit(v, extra);
    endtask

    task automatic header(input int low_len);
        m_low = 1'b1;
        tick(low_len);
        for (int i = 0; i < 8; i++) mbit(i[0], 0);
    endtask

    task automatic sak_slot(input logic exp, input string req, input bit do_tx, input logic [7:0] txb);
        m_low = 1'b0;
        if (do_tx) begin
            tx_byte = txb;
            tx_start = 1'b1;
            tick(1);
            tx_start = 1'b0;
            tick(BT / 4 - 1);
        end else tick(BT / 4);
        chk(line_oe == exp, req, line_oe, exp);
        tick(BT / 2);
        chk(line_oe == 1'b0, req, line_oe, 0);
        tick(BT / 4);
    endtask

    task automatic tx_slot(input logic [7:0] exp);
        logic [7:0] got;
        logic a;
        m_low = 1'b0;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            tick(BT / 4);
            a = line_oe;
            tick(BT / 2);
            chk(line_oe == ~a, "R7 second half inverts first", line_oe, ~a);
            tick(BT / 4);
            got[i] = a;
        end
        chk(got == exp, "R7 transmitted byte", got, exp);
    endtask

    task automatic standby();
        m_low = 1'b0;
        tick(STBY + 50);
    endtask

    initial begin
        int c0;
        tick(5);
        rst = 1'b0;
        tick(1);
        chk(line_oe == 0, "R1 line_oe after reset", line_oe, 0);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(rx_valid == 0 && mak_valid == 0 && miss_edge == 0, "R1 strobes after reset", rx_valid, 0);

        // line high since reset, no rising edge: no standby
        tick(STBY + 50);
        chk(stby_cnt == 0, "R2 standby before any rising edge", stby_cnt, 0);
        header(30);
        chk(busy == 0, "R2 header ignored while not in standby", busy, 0);
        mbit(1'b1, 0);
        m_low = 1'b0;

        // command A
        standby();
        chk(stby_cnt >= 1, "R2 standby after rising edge", stby_cnt, 1);
        chk(busy == 0 && line_oe == 0, "R11 idle after standby", busy, 0);
        sae = 1'b1;
        header(30);
        chk(busy == 1, "R3 header starts command", busy, 1);
        mak(1'b1, 0, 0);
        sak_slot(1'b0, "R5 silent slot after header", 0, 8'h00);
        mbyte(8'hA0, 1);
        mak(1'b1, 0, 1);
        sak_slot(1'b1, "R6 acknowledge driven", 0, 8'h00);
        mbyte(8'h3C, 1);
        mak(1'b1, 0, 1);
        sae = 1'b0;
        sak_slot(1'b0, "R6 acknowledge withheld", 1, 8'h96);
        sae = 1'b1;
        tx_slot(8'h96);
        mak(1'b0, 0, 1);
        sak_slot(1'b1, "R6 acknowledge after stop", 0, 8'h00);
        tick(2);
        chk(busy == 0, "R10 command ended by stop", busy, 0);
        chk(line_oe == 0, "R11 released after command", line_oe, 0);

        // command B straight after, with phase steps at acknowledge bits
        tick(20);
        header(30);
        chk(busy == 1, "R10 new header without standby", busy, 1);
        mak(1'b1, 0, 0);
        sak_slot(1'b0, "R5 silent slot after header", 0, 8'h00);
        mbyte(8'h5A, 1);
        mak(1'b1, 8, 1);
        sak_slot(1'b1, "R8 slot after first phase step", 0, 8'h00);
        mbyte(8'hC3, 1);
        mak(1'b1, 8, 1);
        sak_slot(1'b1, "R8 slot after second phase step", 0, 8'h00);
        mbyte(8'hFF, 1);
        mak(1'b1, 0, 1);
        sak_slot(1'b1, "R6 acknowledge", 0, 8'h00);
        mbyte(8'h01, 1);
        mak(1'b0, 0, 1);
        sak_slot(1'b1, "R6 acknowledge after stop", 0, 8'h00);
        tick(2);
        chk(miss_cnt == 0, "R8 no missed edge across phase steps", miss_cnt, 0);
        chk(exp_rx.size() == 0, "R4 all bytes received", exp_rx.size(), 0);

        // missed edge
        standby();
        header(30);
        mak(1'b1, 0, 0);
        sak_slot(1'b0, "R5 silent slot after header", 0, 8'h00);
        mbyte(8'h81, 1);
        mak(1'b1, 0, 1);
        sak_slot(1'b1, "R6 acknowledge", 0, 8'h00);
        m_low = 1'b0;
        tick(2 * BT);
        chk(miss_cnt == 1, "R9 miss reported", miss_cnt, 1);
        chk(busy == 0, "R9 busy dropped on miss", busy, 0);
        c0 = rx_cnt;
        mbyte(8'h55, 0);
        mak(1'b1, 0, 0);
        m_low = 1'b0;
        tick(BT);
        chk(rx_cnt == c0, "R9 bytes ignored while idle", rx_cnt, c0);
        chk(busy == 0, "R9 still idle", busy, 0);
        c0 = stby_cnt;
        standby();
        chk(stby_cnt == c0 + 1, "R2 standby leaves idle", stby_cnt, c0 + 1);

        // too-short header low pulse
        m_low = 1'b1;
        tick(10);
        m_low = 1'b0;
        tick(100);
        chk(busy == 0, "R3 short low pulse ignored", busy, 0);
        standby();
        header(30);
        mak(1'b1, 0, 0);
        sak_slot(1'b0, "R5 silent slot after header", 0, 8'h00);
        mbyte(8'h00, 1);
        mak(1'b0, 0, 1);
        sak_slot(1'b1, "R6 acknowledge after stop", 0, 8'h00);
        tick(2);
        chk(busy == 0 && line_oe == 0, "R10 R11 quiet after final command", busy, 0);
        chk(exp_rx.size() == 0 && exp_mak.size() == 0, "R4 R6 expected strobes all seen",
            exp_rx.size() + exp_mak.size(), 0);
        chk(miss_cnt == 1, "R9 exactly one miss overall", miss_cnt, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule